// File: doc/BRIEF.md
# Three-Lane Block-Parallel Sparse FIR Filter

This block filters a sample stream with a three-tap sparse FIR whose taps sit at lags 0, 4 and 6: every output is a·x(n) + b·x(n−4) + c·x(n−6). It is a parallel version of that filter. On each clock it takes three consecutive samples at once, in lanes 0, 1 and 2, and returns the three matching filtered outputs together. At the same clock rate this gives three times the sample throughput of a single-rate filter.

Past samples are kept as whole blocks in a two-deep block history. Each output lane picks its delayed operands from the lane and block depth where that sample now sits. The lag-to-operand mapping is derived from the lag and block-size parameters, so it is not written out by hand. A valid strobe marks the cycles that carry a block. Only those cycles advance the history and update the registered outputs.

Top module: `blk3_fir`

## Requirements
- R1: A synchronous active-high reset drives out_valid low, every output lane to zero and the block history to zero. The first blocks after reset therefore see zero for every sample before the reset.
- R2: out_valid equals in_valid delayed by exactly one clock.
- R3: Lane 0 output, one cycle after a valid block k, equals a·x(3k) + b·x(3k−4) + c·x(3k−6). Here x(3k+i) is input lane i of block k.
- R4: Lane 1 output equals a·x(3k+1) + b·x(3k−3) + c·x(3k−5).
- R5: Lane 2 output equals a·x(3k+2) + b·x(3k−2) + c·x(3k−4).
- R6: A cycle with in_valid low is not a sample time. Sample indices count valid blocks only, so idle cycles between blocks do not change any result.
- R7: While in_valid is low, every output lane holds its previous value, whatever is on the data and coefficient inputs.
- R8: Samples and coefficients are 16-bit two's complement. Outputs are 34-bit two's complement and exact for the full input range, including every operand at −32768.
- R9: The coefficients are sampled in the same cycle as the block they apply to. A coefficient change takes effect from the block presented with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the cycle that carries a block of three samples |
| x_blk | input | 3×16 | Input block; element i is sample 3k+i, signed |
| coef_a | input | 16 | Coefficient of the lag-0 tap, signed |
| coef_b | input | 16 | Coefficient of the lag-4 tap, signed |
| coef_c | input | 16 | Coefficient of the lag-6 tap, signed |
| out_valid | output | 1 | Output block valid, one cycle after in_valid |
| y_blk | output | 3×34 | Output block; element i is y(3k+i), signed |

## Verification
A wrong lane or block depth in the operand mapping shows up on the affected lane one cycle after the first block whose delayed sample is nonzero, and it goes on corrupting that lane from then on. A history that advances on idle cycles, or that survives reset, shows up as lag-4 and lag-6 contributions taken from the wrong samples in the very next valid block. The bench runs the same stream through a serial one-sample-at-a-time reference and compares every lane of every output block. It also uses coefficient sets that isolate a single tap, so that each lag's mapping is checked on its own.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

  // Lane that holds sample (phase - lag) in a block of size blk
  function automatic int tap_lane(input int phase, input int lag, input int blk);
    int ofs;
    ofs = phase - lag;
    return ((ofs % blk) + blk) % blk;
  endfunction

  // Number of whole blocks back where sample (phase - lag) lives
  function automatic int tap_dly(input int phase, input int lag, input int blk);
    return (tap_lane(phase, lag, blk) - (phase - lag)) / blk;
  endfunction

  // Block history depth needed to reach a lag
  function automatic int hist_depth(input int lag, input int blk);
    return (lag + blk - 1) / blk;
  endfunction

endpackage

// File: rtl/blk3_hist.sv
module blk3_hist #(
  parameter int BLK   = 3,
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               adv,
  input  logic [BLK-1:0][DW-1:0]             din,
  output logic [DEPTH:0][BLK-1:0][DW-1:0]    taps
);

  // stg[d] holds the block seen d+1 valid blocks ago
  logic [DEPTH-1:0][BLK-1:0][DW-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else if (adv) begin
      for (int d = DEPTH - 1; d > 0; d--) begin
        stg[d] <= stg[d-1];
      end
      stg[0] <= din;
    end
  end

  assign taps = {stg, din};

endmodule

// File: rtl/blk3_lane.sv
module blk3_lane #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int OW = DW + CW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] coef_a,
  input  logic [CW-1:0] coef_b,
  input  logic [CW-1:0] coef_c,
  input  logic [DW-1:0] xa,
  input  logic [DW-1:0] xb,
  input  logic [DW-1:0] xc,
  output logic [OW-1:0] y
);

  localparam int PW = DW + CW;

  logic signed [PW-1:0] pa, pb, pc;
  logic signed [OW-1:0] acc;

  always_comb begin
    pa  = $signed(coef_a) * $signed(xa);
    pb  = $signed(coef_b) * $signed(xb);
    pc  = $signed(coef_c) * $signed(xc);
    acc = OW'(pa) + OW'(pb) + OW'(pc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y <= '0;
    end else if (en) begin
      y <= acc;
    end
  end

endmodule

// File: rtl/blk3_fir.sv
module blk3_fir
  import fir3_pkg::*;
#(
  parameter int BLK   = 3,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int LAG_B = 4,
  parameter int LAG_C = 6,
  parameter int OW    = DW + CW + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [BLK-1:0][DW-1:0] x_blk,
  input  logic [CW-1:0]          coef_a,
  input  logic [CW-1:0]          coef_b,
  input  logic [CW-1:0]          coef_c,
  output logic                   out_valid,
  output logic [BLK-1:0][OW-1:0] y_blk
);

  localparam int LAG_MAX = (LAG_C > LAG_B) ? LAG_C : LAG_B;
  localparam int DEPTH   = hist_depth(LAG_MAX, BLK);

  logic [DEPTH:0][BLK-1:0][DW-1:0] taps;

  blk3_hist #(.BLK(BLK), .DW(DW), .DEPTH(DEPTH)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .adv  (in_valid),
    .din  (x_blk),
    .taps (taps)
  );

  for (genvar p = 0; p < BLK; p++) begin : g_phase
    localparam int LN_B = tap_lane(p, LAG_B, BLK);
    localparam int DL_B = tap_dly(p, LAG_B, BLK);
    localparam int LN_C = tap_lane(p, LAG_C, BLK);
    localparam int DL_C = tap_dly(p, LAG_C, BLK);

    blk3_lane #(.DW(DW), .CW(CW), .OW(OW)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .en     (in_valid),
      .coef_a (coef_a),
      .coef_b (coef_b),
      .coef_c (coef_c),
      .xa     (taps[0][p]),
      .xb     (taps[DL_B][LN_B]),
      .xc     (taps[DL_C][LN_C]),
      .y      (y_blk[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

endmodule

// File: rtl/blk3_fir_chk.sv
module blk3_fir_chk #(
  parameter int BLK = 3,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int OW  = DW + CW + 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [BLK-1:0][DW-1:0] x_blk,
  input logic [CW-1:0]          coef_a,
  input logic [CW-1:0]          coef_b,
  input logic [CW-1:0]          coef_c,
  input logic                   out_valid,
  input logic [BLK-1:0][OW-1:0] y_blk
);

  logic          v_q;
  logic [DW-1:0] x0_q, x1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= 1'b0;
      x0_q <= '0;
      x1_q <= '0;
    end else begin
      v_q  <= in_valid;
      x0_q <= x_blk[0];
      x1_q <= x_blk[1];
    end
  end

  logic signed [OW-1:0] ca_w, cb_w, x0_w, x0q_w, x1q_w;
  logic signed [OW-1:0] pa0, pb_l1, pb_l2;
  assign ca_w  = OW'($signed(coef_a));
  assign cb_w  = OW'($signed(coef_b));
  assign x0_w  = OW'($signed(x_blk[0]));
  assign x0q_w = OW'($signed(x0_q));
  assign x1q_w = OW'($signed(x1_q));
  assign pa0   = ca_w * x0_w;
  assign pb_l1 = cb_w * x0q_w;
  assign pb_l2 = cb_w * x1q_w;

  assert_rst_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && y_blk == '0));

  assert_valid_lat_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_lane0_a_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && coef_b == '0 && coef_c == '0) |=> ($signed(y_blk[0]) == $past(pa0)));

  assert_lane1_b_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && v_q && coef_a == '0 && coef_c == '0) |=> ($signed(y_blk[1]) == $past(pb_l1)));

  assert_lane2_b_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && v_q && coef_a == '0 && coef_c == '0) |=> ($signed(y_blk[2]) == $past(pb_l2)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(y_blk));

endmodule

bind blk3_fir blk3_fir_chk #(.BLK(BLK), .DW(DW), .CW(CW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .x_blk     (x_blk),
  .coef_a    (coef_a),
  .coef_b    (coef_b),
  .coef_c    (coef_c),
  .out_valid (out_valid),
  .y_blk     (y_blk)
);

// File: tb/tb_blk3_fir.sv
module tb_blk3_fir;

  localparam int CLK_PERIOD = 10;
  localparam int BLK = 3;
  localparam int DW  = 16;
  localparam int CW  = 16;
  localparam int OW  = DW + CW + 2;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   in_valid = 1'b0;
  logic [BLK-1:0][DW-1:0] x_blk = '0;
  logic [CW-1:0]          coef_a = '0, coef_b = '0, coef_c = '0;
  logic                   out_valid;
  logic [BLK-1:0][OW-1:0] y_blk;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk3_fir dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .x_blk (x_blk),
    .coef_a (coef_a), .coef_b (coef_b), .coef_c (coef_c),
    .out_valid (out_valid), .y_blk (y_blk)
  );

  typedef struct {
    longint y0, y1, y2;
    string  tag;
  } exp_t;

  exp_t   sb[$];
  longint hist[$];
  longint last_y[3] = '{0, 0, 0};
  int     n_chk = 0, n_fail = 0;
  bit     done = 1'b0;
  int     ca = 0, cb = 0, cc = 0;
  string  lane_req[3] = '{"R3", "R4", "R5"};

  function automatic longint xs(int i);
    return (i < 0) ? 0 : hist[i];
  endfunction

  function automatic longint ref_y(int i);
    return longint'(ca) * xs(i) + longint'(cb) * xs(i - 4) + longint'(cc) * xs(i - 6);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one valid block, expected results pushed to scoreboard
  task automatic send_block(int v0, int v1, int v2, string tag);
    int n;
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    x_blk[0] = DW'(v0); x_blk[1] = DW'(v1); x_blk[2] = DW'(v2);
    coef_a = CW'(ca); coef_b = CW'(cb); coef_c = CW'(cc);
    n = hist.size();
    hist.push_back(longint'($signed(DW'(v0))));
    hist.push_back(longint'($signed(DW'(v1))));
    hist.push_back(longint'($signed(DW'(v2))));
    e.y0 = ref_y(n); e.y1 = ref_y(n + 1); e.y2 = ref_y(n + 2);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Idle cycle with garbage on data and coefficients (R6, R7)
  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    x_blk  = {DW'($urandom), DW'($urandom), DW'($urandom)};
    coef_a = CW'($urandom); coef_b = CW'($urandom); coef_c = CW'($urandom);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    hist.delete();
    last_y = '{0, 0, 0};
    // R1: outputs cleared while and after reset
    chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    for (int l = 0; l < BLK; l++)
      chk($signed(y_blk[l]) == 0, "R1 lane", $signed(y_blk[l]), 0);
  endtask

  // Monitor: pops the scoreboard on each output block
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !done) begin
        if (out_valid) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R2 unexpected out_valid", 1, 0);
          end else begin
            exp_t e;
            longint ev[3];
            e = sb.pop_front();
            ev = '{e.y0, e.y1, e.y2};
            for (int l = 0; l < BLK; l++) begin
              chk($signed(y_blk[l]) == ev[l], {lane_req[l], " ", e.tag},
                  $signed(y_blk[l]), ev[l]);
              last_y[l] = ev[l];
            end
          end
        end else begin
          for (int l = 0; l < BLK; l++)
            chk($signed(y_blk[l]) == last_y[l], "R7 hold", $signed(y_blk[l]), last_y[l]);
        end
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    do_reset();

    // R3 R4 R5: ramp, mixed-sign coefficients
    ca = 3; cb = -5; cc = 7;
    for (int k = 0; k < 10; k++) send_block(3*k + 1, 3*k + 2, 3*k + 3, "ramp");

    // R6 R7: blocks separated by idle cycles
    for (int k = 0; k < 12; k++) begin
      send_block(int'($urandom_range(0, 2000)) - 1000, k * 17, -k * 11, "R6 gaps");
      repeat (k % 3 + 1) idle_cycle();
    end

    // R9 + per-tap isolation: only b, then only c
    ca = 0; cb = 1; cc = 0;
    for (int k = 0; k < 5; k++) send_block(100 + k, 200 + k, 300 + k, "R9 lag4 only");
    ca = 0; cb = 0; cc = 1;
    for (int k = 0; k < 5; k++) send_block(-100 - k, -200 - k, -300 - k, "R9 lag6 only");

    // R8: full-scale negative operands
    ca = -32768; cb = -32768; cc = -32768;
    for (int k = 0; k < 4; k++) send_block(-32768, -32768, -32768, "R8 extreme");
    ca = 32767; cb = -32768; cc = 32767;
    for (int k = 0; k < 4; k++) send_block(32767, -32768, 32767, "R8 mixed extreme");
    idle_cycle(); idle_cycle();

    // R1: reset mid-stream clears history
    do_reset();
    ca = 9; cb = -4; cc = 2;
    for (int k = 0; k < 4; k++) send_block(500 + k, -600, 700, "R1 after reset");

    // Random stream with random valid gaps
    for (int k = 0; k < 300; k++) begin
      ca = int'($urandom_range(0, 65535)) - 32768;
      cb = int'($urandom_range(0, 65535)) - 32768;
      cc = int'($urandom_range(0, 65535)) - 32768;
      send_block(int'($urandom_range(0, 65535)) - 32768,
                 int'($urandom_range(0, 65535)) - 32768,
                 int'($urandom_range(0, 65535)) - 32768, "random");
      if ($urandom_range(0, 3) == 0) idle_cycle();
    end

    idle_cycle(); idle_cycle(); idle_cycle();
    chk(sb.size() == 0, "R2 drained", sb.size(), 0);
    finish_up();
  end

endmodule